// File: doc/BRIEF.md
# Serial-to-Printer Bridge

This block takes characters from an asynchronous serial line and hands each one to a parallel printer port. No processor is involved. The receiver samples the line on a 16x oversampling clock enable, so sixteen enables make one bit time; 1200 bit/s with a 19.2 kHz enable is the intended rate. It checks each start bit at mid-bit and assembles 8-bit characters with no parity and one stop bit. Every accepted character goes into a small first-in first-out buffer.

The printer side takes one character at a time from the buffer, but only while the printer reports that it is free. It drives the character onto eight data lines. One clock later it pulls the active-low strobe down for a set number of clocks, then releases it. The printer's active-low busy input passes through a two-flop synchronizer before the block uses it.

Three flags report status. The first shows that a character is waiting. The second is a sticky overrun flag, set when a character arrives and the buffer has no room. The third is a sticky framing-error flag, set when a stop bit is missing.

Top module: `ser2par_bridge`

## Requirements
- R1: After reset the strobe output is high, the data lines are 0, and the character-available, overrun and framing-error flags are all low.
- R2: A low level on the line starts a possible start bit. The line is sampled again 8 oversampling enables later, and a high level at that point is a false start: nothing is stored and no flag changes.
- R3: After a valid start bit, 8 data bits are taken least significant bit first, one every 16 enables. The character is stored when the stop bit that follows is sampled high.
- R4: Stored characters reach the printer in the order they arrived, each one exactly once.
- R5: The data lines are stable for at least one clock before the strobe falls and stay unchanged until the strobe has risen again. The strobe stays low for exactly STROBE_CLKS clocks (default 4).
- R6: The strobe never falls while the synchronized busy input (low = printer busy) is low. A pending character waits and is printed once busy goes high.
- R7: A stop bit sampled low sets the sticky framing-error flag and discards the character. The receiver then accepts the next character as usual.
- R8: The buffer holds 4 characters. A character that completes while the buffer is full is dropped and sets the sticky overrun flag, and the 4 characters already held still print in order.
- R9: The character-available flag is high exactly while at least one stored character has not yet been taken by the printer side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_line | input | 1 | Serial receive line, idle high |
| prn_busy_n | input | 1 | Printer busy, low = busy, high = free |
| prn_data | output | 8 | Printer data lines |
| prn_strobe_n | output | 1 | Printer strobe, active low |
| char_avail | output | 1 | At least one character waits in the buffer |
| overrun | output | 1 | Sticky: a character was dropped because the buffer was full |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |

## Verification
A receiver that goes out of step with the line shows up within one character time. The byte that reaches the data lines is shifted or has the wrong bits, or the framing-error flag rises on a character that was well formed. A wrong buffer pointer or count shows within a few characters: characters are repeated, lost or reordered, or the overrun flag appears before the fifth unprinted character. A printer sequencer in the wrong state shows within a few clocks: a strobe pulse of the wrong width, data that moves while the strobe is low, or a strobe that falls while the printer reports busy.

// File: rtl/sp_bridge_pkg.sv
// Package: state encodings shared by the serial-to-printer bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package sp_bridge_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        PR_IDLE,
        PR_SETUP,
        PR_STROBE,
        PR_HOLD
    } pr_state_t;
endpackage

// File: rtl/sp_rx.sv
// sp_rx: oversampled asynchronous receiver, no parity, one stop bit.
// Checks the start bit at mid-bit and samples each later bit once per
// OVS enables. Emits a one-clock strobe with the byte on a good stop bit.
// Assumes: OVS is even and >= 4; tick is a single-clock enable.
module sp_rx
    import sp_bridge_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_line,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_vld,
    output logic              frame_err
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int HALF  = OVS / 2;

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic [1:0]        rx_sync;
    logic              rx_s;

    assign rx_s   = rx_sync[1];
    assign byte_o = shreg;

    // Bring the asynchronous line into the clock domain (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rx_line};
    end

    // Frame sequencer: start check, data shift, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            byte_vld  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_W'(HALF - 1)) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            state   <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[DATA_W-1:1]};
                            if (bit_idx == BIT_W'(DATA_W - 1)) state <= RX_STOP;
                            else bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt   <= '0;
                            state <= RX_IDLE;
                            if (rx_s) byte_vld  <= 1'b1;
                            else      frame_err <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sp_fifo.sv
// sp_fifo: small synchronous first-in first-out buffer with sticky overrun.
// A push while full is dropped and flags overrun, even if a pop happens
// in the same clock.
// Assumes: DEPTH is a power of two and >= 2.
module sp_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              overrun
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp;
    logic [AW-1:0]     rp;
    logic [AW:0]       count;
    logic              full;
    logic              do_wr;
    logic              do_rd;

    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign dout  = mem[rp];

    // Storage array; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= din;
    end

    // Pointers, occupancy and the sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/sp_prn.sv
// sp_prn: printer handshake sequencer.
// Synchronizes the active-low busy input. When the printer is free and a
// byte waits, it pops the byte, drives it for one setup clock, holds the
// strobe low for STROBE_CLKS clocks, then keeps the data for one more clock.
// Assumes: SYNC_STAGES >= 2, STROBE_CLKS >= 1.
module sp_prn
    import sp_bridge_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int STROBE_CLKS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_n,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_dout,
    output logic              fifo_pop,
    output logic [DATA_W-1:0] prn_data,
    output logic              prn_strobe_n
);
    localparam int SW = $clog2(STROBE_CLKS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   free_s;
    pr_state_t              state;
    logic [SW-1:0]          cnt;

    assign free_s   = sync_q[SYNC_STAGES-1];
    assign fifo_pop = (state == PR_IDLE) && !fifo_empty && free_s;

    // Busy synchronizer; starts in "busy" until the line is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], busy_n};
    end

    // Handshake sequencer: take byte, setup, strobe pulse, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= PR_IDLE;
            cnt          <= '0;
            prn_data     <= '0;
            prn_strobe_n <= 1'b1;
        end else begin
            case (state)
                PR_IDLE: begin
                    if (fifo_pop) begin
                        prn_data <= fifo_dout;
                        state    <= PR_SETUP;
                    end
                end
                PR_SETUP: begin
                    prn_strobe_n <= 1'b0;
                    cnt          <= SW'(STROBE_CLKS - 1);
                    state        <= PR_STROBE;
                end
                PR_STROBE: begin
                    if (cnt == '0) begin
                        prn_strobe_n <= 1'b1;
                        state        <= PR_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PR_HOLD: state <= PR_IDLE;
                default: state <= PR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ser2par_bridge.sv
// ser2par_bridge: serial receiver -> 4-deep buffer -> printer handshake.
// Assumes: sample_tick runs at 16x the bit rate; prn_busy_n is asynchronous.
module ser2par_bridge #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int STROBE_CLKS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              rx_line,
    input  logic              prn_busy_n,
    output logic [DATA_W-1:0] prn_data,
    output logic              prn_strobe_n,
    output logic              char_avail,
    output logic              overrun,
    output logic              frame_err
);
    logic [DATA_W-1:0] rx_byte;
    logic              rx_vld;
    logic [DATA_W-1:0] q_dout;
    logic              q_empty;
    logic              q_pop;

    sp_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .rx_line   (rx_line),
        .byte_o    (rx_byte),
        .byte_vld  (rx_vld),
        .frame_err (frame_err)
    );

    sp_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_vld),
        .din     (rx_byte),
        .pop     (q_pop),
        .dout    (q_dout),
        .empty   (q_empty),
        .overrun (overrun)
    );

    sp_prn #(.DATA_W(DATA_W), .STROBE_CLKS(STROBE_CLKS), .SYNC_STAGES(SYNC_STAGES)) u_prn (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_n       (prn_busy_n),
        .fifo_empty   (q_empty),
        .fifo_dout    (q_dout),
        .fifo_pop     (q_pop),
        .prn_data     (prn_data),
        .prn_strobe_n (prn_strobe_n)
    );

    // A byte is waiting whenever the buffer holds anything.
    assign char_avail = !q_empty;
endmodule

// File: rtl/sp_bridge_chk.sv
// sp_bridge_chk: port-level protocol checks for ser2par_bridge.
// Assumes: the default two-stage busy synchronizer (fixed $past depths).
module sp_bridge_chk #(
    parameter int DATA_W      = 8,
    parameter int STROBE_CLKS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prn_busy_n,
    input logic [DATA_W-1:0] prn_data,
    input logic              prn_strobe_n,
    input logic              char_avail,
    input logic              overrun,
    input logic              frame_err
);
    logic [15:0] low_cnt;

    // Count consecutive clocks with the strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)            low_cnt <= '0;
        else if (prn_strobe_n) low_cnt <= '0;
        else                   low_cnt <= low_cnt + 1'b1;
    end

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prn_strobe_n || $rose(prn_strobe_n)) |-> $stable(prn_data));

    // R5
    strobe_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= 16'(STROBE_CLKS));

    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prn_strobe_n) |-> (low_cnt == 16'(STROBE_CLKS)));

    // R6
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prn_strobe_n) |-> $past(prn_busy_n, 4));

    // R7
    frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9
    avail_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prn_strobe_n) |-> $past(char_avail, 2));
endmodule

bind ser2par_bridge sp_bridge_chk #(.DATA_W(DATA_W), .STROBE_CLKS(STROBE_CLKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prn_busy_n   (prn_busy_n),
    .prn_data     (prn_data),
    .prn_strobe_n (prn_strobe_n),
    .char_avail   (char_avail),
    .overrun      (overrun),
    .frame_err    (frame_err)
);

// File: tb/ser2par_bridge_bench.sv
module ser2par_bridge_bench;
    localparam int STROBE_CLKS = 4;
    localparam int TICK_DIV    = 4;
    localparam int OVS         = 16;
    localparam int BIT_CLKS    = OVS * TICK_DIV;
    localparam int NVEC        = 5;
    // {stimulus byte, expected printed byte}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h55, 8'h55}, {8'hA3, 8'hA3}, {8'h00, 8'h00}, {8'hFF, 8'hFF}, {8'h81, 8'h81}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sample_tick;
    logic       rx_line;
    logic       prn_busy_n;
    logic [7:0] prn_data;
    logic       prn_strobe_n;
    logic       char_avail;
    logic       overrun;
    logic       frame_err;

    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] prn_log [16];
    int         log_n = 0;
    logic       mon_on = 1'b0;

    ser2par_bridge #(.STROBE_CLKS(STROBE_CLKS)) u_ser2par_bridge (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_tick  (sample_tick),
        .rx_line      (rx_line),
        .prn_busy_n   (prn_busy_n),
        .prn_data     (prn_data),
        .prn_strobe_n (prn_strobe_n),
        .char_avail   (char_avail),
        .overrun      (overrun),
        .frame_err    (frame_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Oversampling enable: one clock in every TICK_DIV.
    initial begin
        sample_tick = 1'b0;
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            sample_tick = 1'b1;
            @(negedge clk);
            sample_tick = 1'b0;
        end
    end

    // Printer model: logs each strobed byte and checks the R5 timing.
    initial begin
        logic       prev_s = 1'b1;
        logic [7:0] prev_d = '0;
        logic [7:0] held   = '0;
        int         width  = 0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (prev_s && !prn_strobe_n) begin
                    if (log_n < 16) prn_log[log_n] = prn_data;
                    log_n++;
                    chk("R5 setup", {24'b0, prn_data}, {24'b0, prev_d});
                    held  = prn_data;
                    width = 1;
                end else if (!prn_strobe_n) begin
                    width++;
                    chk("R5 hold", {24'b0, prn_data}, {24'b0, held});
                end else if (!prev_s) begin
                    chk("R5 width", width, STROBE_CLKS);
                    chk("R5 hold at rise", {24'b0, prn_data}, {24'b0, held});
                end
            end
            prev_s = prn_strobe_n;
            prev_d = prn_data;
        end
    end

    task automatic do_reset();
        mon_on     = 1'b0;
        rst_n      = 1'b0;
        rx_line    = 1'b1;
        prn_busy_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        log_n = 0;
        repeat (4) @(negedge clk);
        mon_on = 1'b1;
    endtask

    task automatic send(input logic [7:0] b, input logic stop_bit);
        rx_line = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx_line = stop_bit;
        repeat (BIT_CLKS) @(negedge clk);
        rx_line = 1'b1;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(negedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int base;
        do_reset();
        // R1 reset state
        chk("R1 strobe", prn_strobe_n, 1);
        chk("R1 data", prn_data, 0);
        chk("R1 avail", char_avail, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 frame", frame_err, 0);

        // R3 R4 R9 table of characters, printer free
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][15:8], 1'b1);
            settle(40);
            chk("R3 count", log_n, v + 1);
            chk("R4 byte", {24'b0, prn_log[v]}, {24'b0, VEC[v][7:0]});
            chk("R9 drained", char_avail, 0);
        end

        // R6 busy holds the character back
        base = log_n;
        prn_busy_n = 1'b0;
        send(8'h3C, 1'b1);
        settle(60);
        chk("R6 no strobe", log_n, base);
        chk("R6 strobe idle", prn_strobe_n, 1);
        chk("R9 pending", char_avail, 1);
        prn_busy_n = 1'b1;
        settle(30);
        chk("R6 released", log_n, base + 1);
        chk("R6 byte", {24'b0, prn_log[base]}, 32'h3C);
        chk("R9 taken", char_avail, 0);

        // R2 false start: low for a quarter bit only
        base = log_n;
        rx_line = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rx_line = 1'b1;
        settle(3 * BIT_CLKS);
        chk("R2 nothing stored", log_n, base);
        chk("R2 no avail", char_avail, 0);
        chk("R2 no frame", frame_err, 0);
        send(8'h5A, 1'b1);
        settle(40);
        chk("R2 next ok", {24'b0, prn_log[base]}, 32'h5A);

        // R7 missing stop bit
        base = log_n;
        send(8'hC3, 1'b0);
        settle(2 * BIT_CLKS);
        chk("R7 frame set", frame_err, 1);
        chk("R7 discarded", log_n, base);
        chk("R7 no avail", char_avail, 0);
        send(8'h99, 1'b1);
        settle(40);
        chk("R7 recover", {24'b0, prn_log[base]}, 32'h99);
        chk("R7 sticky", frame_err, 1);

        // R1 reset clears sticky flags
        do_reset();
        chk("R1 frame cleared", frame_err, 0);

        // R8 overrun: five characters while the printer is busy
        prn_busy_n = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            send(8'(k * 8'h11), 1'b1);
            settle(10);
            chk("R8 overrun timing", overrun, (k == 5) ? 1 : 0);
        end
        chk("R9 full avail", char_avail, 1);
        chk("R8 nothing printed", log_n, 0);
        prn_busy_n = 1'b1;
        settle(80);
        chk("R8 four printed", log_n, 4);
        for (int k = 0; k < 4; k++)
            chk("R8 order", {24'b0, prn_log[k]}, 32'((k + 1) * 8'h11));
        chk("R8 sticky", overrun, 1);
        chk("R9 empty", char_avail, 0);

        finish_run();
    end
endmodule